// File: doc/BRIEF.md
# Module Soft-Reset and Enable Sequencer

This block owns the module-level software reset of a bus peripheral and the handshake that reports when that reset is complete. Software reaches it through a simple write port. A write to the system-configuration word with the soft-reset bit set starts an internal reset pulse. That pulse lasts a fixed number of clocks and forces every functional register of the peripheral back to zero. The soft-reset bit reads back as 1 while the pulse runs and then clears by itself.

Completion is not reported as soon as the pulse ends. The reset-done flag rises only after software has set the module enable bit of the control word following the soft reset. The expected sequence is: disable the module, issue the soft reset, enable the module, then poll for done. Once the flag is set, it stays set until the next soft reset, even if the module is disabled again. The control word also carries the master/slave and transmitter/receiver selects, and the block presents them as decoded outputs.

Top module: `modrst_seq`

## Requirements
- R1: After the hardware reset (`rst_n` low), `ctrl_q` and `syscfg_q` are zero and `func_rst`, `mod_en`, `mst_mode`, `tx_mode` and `rst_done` are low.
- R2: A write to address 1 with data bit 1 set is a soft-reset request. It drives `func_rst` high on the clock after the write for exactly `RST_CYCLES` cycles (default 8).
- R3: From the write edge of a soft-reset request until `func_rst` falls, `ctrl_q` stays zero. Control writes (address 0) in that window are ignored and do not survive the pulse.
- R4: Bit 1 of `syscfg_q` reads 1 exactly while `func_rst` is high and reads 0 once the pulse ends.
- R5: A soft reset returns every configuration bit of both words to zero, including the non-reset bits of the system-configuration word.
- R6: A soft-reset request clears `rst_done`. At the end of the pulse `rst_done` stays low while the enable bit (control bit 15) is 0. It rises on the clock after the enable bit is written to 1.
- R7: Once high, `rst_done` stays high when control bit 15 is later cleared. Only a new soft-reset request clears it.
- R8: If a soft-reset request is written on the same clock on which `rst_done` would otherwise rise, the request wins: `rst_done` stays low and a new pulse starts.
- R9: `mod_en`, `mst_mode` and `tx_mode` follow control bits 15, 10 and 9 (1 = enabled, master, transmitter).
- R10: A soft-reset request written while a pulse is running restarts the count, so `func_rst` stays high for `RST_CYCLES` cycles after the last request.
- R11: After the hardware reset, with no soft reset issued, the first write of the enable bit raises `rst_done` on the following clock.
- R12: Writes to addresses other than 0 and 1 change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (2) | Write address: 0 = control, 1 = system configuration |
| wr_data | input | DW (16) | Write data |
| ctrl_q | output | DW (16) | Current control word |
| syscfg_q | output | DW (16) | System-configuration word; bit 1 = reset in progress |
| func_rst | output | 1 | Internal reset to the peripheral's functional registers |
| mod_en | output | 1 | Module enable (control bit 15) |
| mst_mode | output | 1 | 1 = master, 0 = slave (control bit 10) |
| tx_mode | output | 1 | 1 = transmitter, 0 = receiver (control bit 9) |
| rst_done | output | 1 | Reset-done status |

## Verification
Two events can fall on the same clock: setting the done flag and accepting a new soft-reset request. The bench provokes this by writing the enable bit on one clock and a soft-reset request on the very next clock, which is the clock on which done would rise. The result is correct only if `rst_done` stays low, `func_rst` is high and the control word is zero afterwards. A second collision places a control write on the last cycle of the pulse, and that write must not survive.

// File: rtl/modrst_pkg.sv
package modrst_pkg;
  parameter int DW = 16;
  parameter int AW = 2;

  localparam int SRST_BIT = 1;
  localparam int EN_BIT   = 15;
  localparam int MST_BIT  = 10;
  localparam int TRX_BIT  = 9;

  typedef enum logic [AW-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_SYSCFG = 2'd1
  } reg_addr_e;

  function automatic logic is_srst_req(input logic we, input logic [AW-1:0] addr,
                                       input logic [DW-1:0] data);
    return we && (addr == ADDR_SYSCFG) && data[SRST_BIT];
  endfunction

  function automatic logic is_wr_to(input logic we, input logic [AW-1:0] addr,
                                    input reg_addr_e target);
    return we && (addr == target);
  endfunction

  function automatic logic [DW-1:0] drop_srst(input logic [DW-1:0] data);
    logic [DW-1:0] m;
    m = '1;
    m[SRST_BIT] = 1'b0;
    return data & m;
  endfunction
endpackage

// File: rtl/modrst_pulse.sv
module modrst_pulse #(
  parameter int RST_CYCLES = 8,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_req,
  output logic active
);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (srst_req)    cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/modrst_regs.sv
module modrst_regs
  import modrst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst_req,
  input  logic          pulse_active,
  input  logic          ctrl_wr,
  input  logic          sys_wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] sys_cfg_q
);
  logic clear_now;
  assign clear_now = srst_req || pulse_active;

  always_ff @(posedge clk) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (clear_now) ctrl_q <= '0;
    else if (ctrl_wr)  ctrl_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sys_cfg_q <= '0;
    else if (clear_now) sys_cfg_q <= '0;
    else if (sys_wr)   sys_cfg_q <= drop_srst(wr_data);
  end
endmodule

// File: rtl/modrst_done.sv
module modrst_done (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_req,
  input  logic pulse_active,
  input  logic enable,
  output logic done,
  output logic done_set
);
  logic pending_q;

  assign done_set = pending_q && !pulse_active && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b1;
      done      <= 1'b0;
    end else if (srst_req) begin
      pending_q <= 1'b1;
      done      <= 1'b0;
    end else if (done_set) begin
      pending_q <= 1'b0;
      done      <= 1'b1;
    end
  end
endmodule

// File: rtl/modrst_seq.sv
module modrst_seq
  import modrst_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] syscfg_q,
  output logic          func_rst,
  output logic          mod_en,
  output logic          mst_mode,
  output logic          tx_mode,
  output logic          rst_done
);
  logic          srst_req;
  logic          ctrl_wr;
  logic          sys_wr;
  logic          pulse_active;
  logic          done_set;
  logic [DW-1:0] sys_cfg_q;

  assign srst_req = is_srst_req(wr_en, wr_addr, wr_data);
  assign ctrl_wr  = is_wr_to(wr_en, wr_addr, ADDR_CTRL);
  assign sys_wr   = is_wr_to(wr_en, wr_addr, ADDR_SYSCFG);

  modrst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .active(pulse_active)
  );

  modrst_regs u_regs (
    .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .pulse_active(pulse_active),
    .ctrl_wr(ctrl_wr), .sys_wr(sys_wr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .sys_cfg_q(sys_cfg_q)
  );

  modrst_done u_done (
    .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .pulse_active(pulse_active),
    .enable(ctrl_q[EN_BIT]), .done(rst_done), .done_set(done_set)
  );

  always_comb begin
    syscfg_q = sys_cfg_q;
    syscfg_q[SRST_BIT] = pulse_active;
  end

  assign func_rst = pulse_active;
  assign mod_en   = ctrl_q[EN_BIT];
  assign mst_mode = ctrl_q[MST_BIT];
  assign tx_mode  = ctrl_q[TRX_BIT];
endmodule

// File: rtl/modrst_seq_chk.sv
module modrst_seq_chk
  import modrst_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_req,
  input logic          done_set,
  input logic          func_rst,
  input logic          rst_done,
  input logic          mod_en,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] syscfg_q
);
  logic [CW-1:0] win_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          win_q <= '0;
    else if (srst_req)   win_q <= CW'(RST_CYCLES);
    else if (win_q != 0) win_q <= win_q - 1'b1;
  end

  // R2 R10
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst == (win_q != '0));

  // R2
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> func_rst);

  // R3
  ctrl_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |-> (ctrl_q == '0));

  // R4
  srst_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syscfg_q[SRST_BIT] == func_rst);

  // R6
  done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_done) |-> ($past(mod_en) && !$past(func_rst)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && !srst_req) |=> rst_done);

  // R8
  srst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_req && done_set) |=> (!rst_done && func_rst));
endmodule

bind modrst_seq modrst_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_req(srst_req), .done_set(done_set),
  .func_rst(func_rst), .rst_done(rst_done), .mod_en(mod_en),
  .ctrl_q(ctrl_q), .syscfg_q(syscfg_q)
);

// File: tb/modrst_seq_bench.sv
`timescale 1ns/1ps
module modrst_seq_bench;
  localparam int RC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_q, syscfg_q;
  logic        func_rst, mod_en, mst_mode, tx_mode, rst_done;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  modrst_seq #(.RST_CYCLES(RC)) u_modrst_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .syscfg_q(syscfg_q), .func_rst(func_rst), .mod_en(mod_en),
    .mst_mode(mst_mode), .tx_mode(tx_mode), .rst_done(rst_done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capturing edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_por;
    chk("R1 ctrl", ctrl_q, 16'h0);
    chk("R1 syscfg", syscfg_q, 16'h0);
    chk("R1 outs", {11'h0, func_rst, mod_en, mst_mode, tx_mode, rst_done}, 16'h0);
    wr(2'd3, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    chk("R12 ctrl", ctrl_q, 16'h0);
    chk("R12 syscfg", syscfg_q, 16'h0);
    chk("R12 rst", {15'h0, func_rst}, 16'h0);
    wr(2'd0, 16'h8000);
    chk("R11 not yet", {15'h0, rst_done}, 16'h0);
    idle(1);
    chk("R11 done", {15'h0, rst_done}, 16'h1);
  endtask

  task automatic t_pulse;
    wr(2'd1, 16'h00F0);
    wr(2'd0, 16'h8600);
    chk("R9 en/mst/tx", {13'h0, mod_en, mst_mode, tx_mode}, 16'h7);
    chk("R9 ctrl", ctrl_q, 16'h8600);
    chk("R5 pre", syscfg_q, 16'h00F0);
    wr(2'd1, 16'h0002);
    chk("R6 done clr", {15'h0, rst_done}, 16'h0);
    chk("R5 ctrl", ctrl_q, 16'h0);
    chk("R5 syscfg", syscfg_q, 16'h0002);
    for (int i = 0; i < RC; i++) begin
      chk("R2 high", {15'h0, func_rst}, 16'h1);
      chk("R4 bit", {15'h0, syscfg_q[1]}, 16'h1);
      if (i == 3) begin
        wr(2'd0, 16'h8600);
        chk("R3 ignored", ctrl_q, 16'h0);
      end else idle(1);
    end
    chk("R2 low", {15'h0, func_rst}, 16'h0);
    chk("R4 self-clear", syscfg_q, 16'h0);
    chk("R3 after", ctrl_q, 16'h0);
    idle(3);
    chk("R6 wait en", {15'h0, rst_done}, 16'h0);
    wr(2'd0, 16'h8000);
    chk("R6 one later", {15'h0, rst_done}, 16'h0);
    idle(1);
    chk("R6 done", {15'h0, rst_done}, 16'h1);
    wr(2'd0, 16'h0000);
    idle(2);
    chk("R7 sticky", {15'h0, rst_done}, 16'h1);
  endtask

  task automatic t_retrigger;
    wr(2'd1, 16'h0002);
    idle(4);
    wr(2'd1, 16'h0002);
    for (int i = 0; i < RC; i++) begin
      chk("R10 high", {15'h0, func_rst}, 16'h1);
      if (i == RC - 1) begin
        wr(2'd0, 16'h8000);
      end else idle(1);
    end
    chk("R10 low", {15'h0, func_rst}, 16'h0);
    chk("R3 last-cycle write", ctrl_q, 16'h0);
  endtask

  task automatic t_collide;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h0002);
    chk("R8 done low", {15'h0, rst_done}, 16'h0);
    chk("R8 pulse", {15'h0, func_rst}, 16'h1);
    chk("R8 ctrl", ctrl_q, 16'h0);
    idle(RC + 2);
    chk("R8 still low", {15'h0, rst_done}, 16'h0);
    wr(2'd0, 16'h8000);
    idle(1);
    chk("R6 after collide", {15'h0, rst_done}, 16'h1);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        t_por();
        t_pulse();
        t_retrigger();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule